// File: doc/BRIEF.md
# Secure-filtered interrupt state bitmaps

This block holds the per-interrupt state bits for the shared interrupts of an interrupt controller: enable, pending, active, trigger mode (edge or level) and group. Software reaches this state over a 32-bit single-cycle register bus. The bus carries a secure attribute with each access. Enable, pending and active each have a pair of windows. One window sets bits where the written data has a 1, and the other clears bits where the written data has a 1. Reading either window of a pair returns the same state.

Every access passes through a per-bit access mask. A secure access sees everything. A non-secure access, while security is enabled, sees the interrupts whose group bit is 1. Through a 2-bit permission field per interrupt, it may also see some pending and active operations on the other interrupts. A global security-disable flag turns all masking off and is sticky until reset.

The block samples the shared interrupt lines every cycle. A rising edge latches pending for interrupts configured as edge-triggered. For level-triggered interrupts, a pending read also reflects the live line.

Top module: `irqsec_bitmap`

## Requirements
- R1: After reset every state bit, the security-disable flag, `bus_rdata` and `bus_err` are zero.
- R2: Word k of each window covers interrupts 32k..32k+31, bit i standing for interrupt 32k+i. The windows are: group at 0x000, enable set/clear at 0x080/0x100, pending set/clear at 0x180/0x200, and active set/clear at 0x280/0x300. In a set window a 1 sets the bit and a 0 leaves it. In a clear window a 1 clears the bit. Both windows of a pair read the same state.
- R3: A non-secure access while security is enabled gets a mask equal to the group bits for the enable windows, active writes and trigger-mode accesses. Bits outside the mask read 0 and ignore writes.
- R4: The permission field P of an interrupt widens the non-secure mask beyond the group bit. P>=1 adds pending-set writes and reads. P>=2 adds pending-clear writes and reads, and active reads. P=0 adds nothing.
- R5: Words for interrupts 0..31 and for interrupts at or above NUM_IRQ read 0 and ignore writes in every window.
- R6: A 0-to-1 change on line j (interrupt 32+j) sets its pending bit only when the interrupt is edge-triggered. A line that stays high does not set it again.
- R7: A pending read returns the stored bit ORed with (sampled line AND level-triggered).
- R8: The trigger window at 0x400 uses 2 bits per interrupt, 16 interrupts per word, with word m covering interrupts 16m..16m+15. Bit 2j+1 is the edge flag of interrupt 16m+j, and bit 2j reads 0 and is ignored on write. Only flags inside the R3 mask are updated.
- R9: The permission window at 0x500 (2 bits per interrupt, same layout as R8, with field j in bits 2j+1:2j) is readable and writable only by secure accesses while security is enabled. The group window is hidden (reads 0, ignores writes) from non-secure accesses while security is enabled.
- R10: Bit 0 at 0x600 is the security-disable flag. A secure write of 1 sets it, and non-secure writes are ignored. Once set, it stays set until reset and makes every access mask all ones.
- R11: Read data appears on `bus_rdata` one cycle after the access. `bus_err` is high for exactly the cycle after an access to a misaligned or unmapped address (for example 0x380 or 0x700).
- R12: When an edge latch and a pending-clear write hit the same bit in the same cycle, the pending bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_secure | input | 1 | Secure attribute of the access |
| irq_lines | input | NUM_IRQ-32 | Shared interrupt input lines |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| bus_err | output | 1 | Unmapped-address flag, the cycle after the access |

## Verification
Every bus result is registered once. A read or error flag driven at one falling edge is sampled at the next falling edge, after the single rising edge that loads it. A line change driven at a falling edge is sampled and latched at the following rising edge. The read of its pending effect therefore starts on the next cycle, and its data is taken one cycle later. The case where an edge latch and a clear write share one cycle drives both at the same falling edge, so that they land at one rising edge.

// File: rtl/irqsec_pkg.sv
package irqsec_pkg;

   localparam int ADDR_W = 12;
   localparam int WORD_W = 32;

   typedef enum logic [3:0] {
      WIN_NONE,
      WIN_GROUP,
      WIN_EN_SET,
      WIN_EN_CLR,
      WIN_PD_SET,
      WIN_PD_CLR,
      WIN_AC_SET,
      WIN_AC_CLR,
      WIN_EDGE,
      WIN_NSAC,
      WIN_CTRL
   } win_e;

   function automatic win_e win_of(input logic [ADDR_W-1:0] a);
      win_e w;
      w = WIN_NONE;
      if (a[1:0] == 2'b00) begin
         case (a[11:7])
            5'd0:        w = WIN_GROUP;
            5'd1:        w = WIN_EN_SET;
            5'd2:        w = WIN_EN_CLR;
            5'd3:        w = WIN_PD_SET;
            5'd4:        w = WIN_PD_CLR;
            5'd5:        w = WIN_AC_SET;
            5'd6:        w = WIN_AC_CLR;
            5'd8, 5'd9:  w = WIN_EDGE;
            5'd10, 5'd11: w = WIN_NSAC;
            5'd12:       w = (a[6:2] == 5'd0) ? WIN_CTRL : WIN_NONE;
            default:     w = WIN_NONE;
         endcase
      end
      return w;
   endfunction

   // put 16 flags on the odd bits of a word
   function automatic logic [31:0] spread16(input logic [15:0] f);
      logic [31:0] r;
      r = '0;
      for (int j = 0; j < 16; j++) r[2*j+1] = f[j];
      return r;
   endfunction

   // pick the odd bits of a word
   function automatic logic [15:0] odd16(input logic [31:0] v);
      logic [15:0] r;
      for (int j = 0; j < 16; j++) r[j] = v[2*j+1];
      return r;
   endfunction

endpackage

// File: rtl/irqsec_decode.sv
module irqsec_decode
   import irqsec_pkg::*;
#(
   parameter int NW = 1
) (
   input  logic [ADDR_W-1:0] addr,
   output win_e              win,
   output logic [NW-1:0]     word_sel,
   output logic              half
);
   logic two_bit;

   assign win     = win_of(addr);
   assign two_bit = (win == WIN_EDGE) || (win == WIN_NSAC);
   assign half    = addr[2];

   for (genvar k = 0; k < NW; k++) begin : g_sel
      localparam logic [4:0] KW = 5'(k + 1);
      assign word_sel[k] = two_bit ? (addr[7:3] == KW) : (addr[6:2] == KW);
   end
endmodule

// File: rtl/irqsec_word.sv
module irqsec_word
   import irqsec_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic [31:0] irq_in,
   input  logic        wr,
   input  logic        sel,
   input  win_e        win,
   input  logic        half,
   input  logic [31:0] wdata,
   input  logic        secure,
   input  logic        sec_dis,
   output logic [31:0] rd_word
);
   logic [31:0] group_q, en_q, pd_q, ac_q, edge_q, lvl_q;
   logic [63:0] nsac_q;
   logic [31:0] ge1, ge2, m_grp, m_ge1, m_ge2;
   logic [31:0] rise_e, pd_view, pd_set, pd_clr, grp_edge;
   logic        mask_on, grp_ok, nsac_ok, hit;

   assign mask_on = !secure && !sec_dis;
   assign grp_ok  = secure || sec_dis;
   assign nsac_ok = secure && !sec_dis;
   assign hit     = wr && sel;

   always_comb begin
      for (int j = 0; j < 32; j++) begin
         ge1[j] = nsac_q[2*j] | nsac_q[2*j+1];
         ge2[j] = nsac_q[2*j+1];
      end
   end

   assign m_grp = mask_on ? group_q         : '1;
   assign m_ge1 = mask_on ? (group_q | ge1) : '1;
   assign m_ge2 = mask_on ? (group_q | ge2) : '1;

   assign rise_e   = irq_in & ~lvl_q & edge_q;
   assign pd_view  = pd_q | (lvl_q & ~edge_q);
   assign pd_set   = (hit && win == WIN_PD_SET) ? (wdata & m_ge1) : '0;
   assign pd_clr   = (hit && win == WIN_PD_CLR) ? (wdata & m_ge2) : '0;
   assign grp_edge = edge_q & m_grp;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         group_q <= '0;
         en_q    <= '0;
         pd_q    <= '0;
         ac_q    <= '0;
         edge_q  <= '0;
         lvl_q   <= '0;
         nsac_q  <= '0;
      end else begin
         lvl_q <= irq_in;
         pd_q  <= ((pd_q | pd_set) & ~pd_clr) | rise_e;
         if (hit) begin
            case (win)
               WIN_GROUP:  if (grp_ok) group_q <= wdata;
               WIN_EN_SET: en_q <= en_q | (wdata & m_grp);
               WIN_EN_CLR: en_q <= en_q & ~(wdata & m_grp);
               WIN_AC_SET: ac_q <= ac_q | (wdata & m_grp);
               WIN_AC_CLR: ac_q <= ac_q & ~(wdata & m_grp);
               WIN_EDGE:   edge_q[half*16 +: 16] <=
                              (edge_q[half*16 +: 16] & ~m_grp[half*16 +: 16]) |
                              (odd16(wdata) & m_grp[half*16 +: 16]);
               WIN_NSAC:   if (nsac_ok) nsac_q[half*32 +: 32] <= wdata;
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      case (win)
         WIN_GROUP:              rd_word = grp_ok ? group_q : '0;
         WIN_EN_SET, WIN_EN_CLR: rd_word = en_q & m_grp;
         WIN_PD_SET:             rd_word = pd_view & m_ge1;
         WIN_PD_CLR:             rd_word = pd_view & m_ge2;
         WIN_AC_SET, WIN_AC_CLR: rd_word = ac_q & m_ge2;
         WIN_EDGE:               rd_word = spread16(grp_edge[half*16 +: 16]);
         WIN_NSAC:               rd_word = nsac_ok ? nsac_q[half*32 +: 32] : '0;
         default:                rd_word = '0;
      endcase
   end

   AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_e != '0) |=> ((pd_q & $past(rise_e)) == $past(rise_e))) else $error("edge latch"); // R6

   AST_NS_EN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && (win == WIN_EN_SET || win == WIN_EN_CLR) && mask_on)
      |=> (((en_q ^ $past(en_q)) & ~$past(group_q)) == '0)) else $error("ns enable mask"); // R3

   AST_NS_PCLR_GRADE: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && win == WIN_PD_CLR && mask_on)
      |=> ((pd_q & $past(pd_q & ~m_ge2)) == $past(pd_q & ~m_ge2))) else $error("pend clr grade"); // R4

   AST_NSAC_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && win == WIN_NSAC && !nsac_ok) |=> $stable(nsac_q)) else $error("nsac guard"); // R9
endmodule

// File: rtl/irqsec_bitmap.sv
module irqsec_bitmap
   import irqsec_pkg::*;
#(
   parameter int NUM_IRQ = 64
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_valid,
   input  logic                 bus_write,
   input  logic [11:0]          bus_addr,
   input  logic [31:0]          bus_wdata,
   input  logic                 bus_secure,
   input  logic [NUM_IRQ-33:0]  irq_lines,
   output logic [31:0]          bus_rdata,
   output logic                 bus_err
);
   localparam int NSPI = NUM_IRQ - 32;
   localparam int NW   = NSPI / WORD_W;

   if (NUM_IRQ % 32 != 0 || NUM_IRQ < 64 || NUM_IRQ > 1024) begin : g_bad_cfg
      $error("NUM_IRQ must be a multiple of 32 in 64..1024");
   end

   win_e            win;
   logic [NW-1:0]   word_sel;
   logic            half;
   logic            sec_dis_q;
   logic            wr;
   logic [31:0]     rd_word [NW];
   logic [31:0]     rd_mux;

   assign wr = bus_valid && bus_write;

   irqsec_decode #(.NW(NW)) u_dec (
      .addr     (bus_addr),
      .win      (win),
      .word_sel (word_sel),
      .half     (half)
   );

   for (genvar k = 0; k < NW; k++) begin : g_word
      irqsec_word u_word (
         .clk     (clk),
         .rst_n   (rst_n),
         .irq_in  (irq_lines[k*32 +: 32]),
         .wr      (wr),
         .sel     (word_sel[k]),
         .win     (win),
         .half    (half),
         .wdata   (bus_wdata),
         .secure  (bus_secure),
         .sec_dis (sec_dis_q),
         .rd_word (rd_word[k])
      );
   end

   always_comb begin
      rd_mux = '0;
      for (int k = 0; k < NW; k++)
         if (word_sel[k]) rd_mux = rd_mux | rd_word[k];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rdata <= '0;
         bus_err   <= 1'b0;
         sec_dis_q <= 1'b0;
      end else begin
         bus_err <= bus_valid && (win == WIN_NONE);
         if (bus_valid && !bus_write)
            bus_rdata <= (win == WIN_CTRL) ? {31'b0, sec_dis_q} :
                         (win == WIN_NONE) ? 32'b0 : rd_mux;
         if (wr && win == WIN_CTRL && bus_secure && bus_wdata[0])
            sec_dis_q <= 1'b1;
      end
   end

   AST_ERR_MISALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_addr[1:0] != 2'b00) |=> bus_err) else $error("misalign err"); // R11

   AST_RAZ_INTERNAL: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_write && bus_addr == 12'h080) |=> (bus_rdata == 32'b0)) else $error("internal raz"); // R5

   AST_SECDIS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      sec_dis_q |=> sec_dis_q) else $error("sec dis sticky"); // R10
endmodule

// File: tb/irqsec_bitmap_bench.sv
`timescale 1ns/1ps
module irqsec_bitmap_bench;
   localparam int NUM_IRQ = 64;

   typedef struct packed {
      logic        wr;
      logic        sec;
      logic [11:0] addr;
      logic [31:0] data;
      logic [31:0] exp;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 44;
   localparam vec_t VEC [NV] = '{
      '{1'b1,1'b1,12'h004,32'h0000FFFF,32'h0,8'd9},        // R9 group set
      '{1'b0,1'b1,12'h004,32'h0,32'h0000FFFF,8'd9},        // R9
      '{1'b0,1'b0,12'h004,32'h0,32'h0,8'd9},               // R9 ns hidden
      '{1'b1,1'b1,12'h084,32'h0F0F0F0F,32'h0,8'd2},        // R2
      '{1'b0,1'b1,12'h104,32'h0,32'h0F0F0F0F,8'd2},        // R2
      '{1'b1,1'b1,12'h104,32'h00000003,32'h0,8'd2},        // R2
      '{1'b0,1'b1,12'h084,32'h0,32'h0F0F0F0C,8'd2},        // R2
      '{1'b1,1'b1,12'h084,32'h0,32'h0,8'd2},               // R2 zero write
      '{1'b0,1'b1,12'h084,32'h0,32'h0F0F0F0C,8'd2},        // R2
      '{1'b0,1'b0,12'h084,32'h0,32'h00000F0C,8'd3},        // R3
      '{1'b1,1'b0,12'h084,32'hFFFFFFFF,32'h0,8'd3},        // R3
      '{1'b0,1'b1,12'h084,32'h0,32'h0F0FFFFF,8'd3},        // R3
      '{1'b1,1'b0,12'h104,32'hFFFFFFFF,32'h0,8'd3},        // R3
      '{1'b0,1'b1,12'h084,32'h0,32'h0F0F0000,8'd3},        // R3
      '{1'b1,1'b1,12'h50C,32'h00000039,32'h0,8'd9},        // R9
      '{1'b0,1'b1,12'h50C,32'h0,32'h00000039,8'd9},        // R9
      '{1'b0,1'b0,12'h50C,32'h0,32'h0,8'd9},               // R9
      '{1'b1,1'b0,12'h50C,32'hFFFFFFFF,32'h0,8'd9},        // R9
      '{1'b0,1'b1,12'h50C,32'h0,32'h00000039,8'd9},        // R9
      '{1'b1,1'b0,12'h184,32'hFFFFFFFF,32'h0,8'd4},        // R4
      '{1'b0,1'b1,12'h184,32'h0,32'h0007FFFF,8'd4},        // R4
      '{1'b0,1'b0,12'h204,32'h0,32'h0006FFFF,8'd4},        // R4
      '{1'b1,1'b0,12'h204,32'hFFFFFFFF,32'h0,8'd4},        // R4
      '{1'b0,1'b1,12'h184,32'h0,32'h00010000,8'd4},        // R4
      '{1'b1,1'b1,12'h284,32'h000F0000,32'h0,8'd4},        // R4
      '{1'b0,1'b0,12'h284,32'h0,32'h00060000,8'd4},        // R4
      '{1'b0,1'b1,12'h304,32'h0,32'h000F0000,8'd2},        // R2
      '{1'b1,1'b0,12'h304,32'hFFFFFFFF,32'h0,8'd3},        // R3
      '{1'b0,1'b1,12'h284,32'h0,32'h000F0000,8'd3},        // R3
      '{1'b1,1'b1,12'h304,32'hFFFFFFFF,32'h0,8'd2},        // R2
      '{1'b0,1'b1,12'h284,32'h0,32'h0,8'd2},               // R2
      '{1'b1,1'b1,12'h408,32'h0000000F,32'h0,8'd8},        // R8
      '{1'b0,1'b1,12'h408,32'h0,32'h0000000A,8'd8},        // R8
      '{1'b1,1'b0,12'h40C,32'hFFFFFFFF,32'h0,8'd8},        // R8
      '{1'b0,1'b1,12'h40C,32'h0,32'h0,8'd8},               // R8
      '{1'b1,1'b1,12'h40C,32'h00000002,32'h0,8'd8},        // R8
      '{1'b0,1'b1,12'h40C,32'h0,32'h00000002,8'd8},        // R8
      '{1'b1,1'b1,12'h080,32'hFFFFFFFF,32'h0,8'd5},        // R5
      '{1'b0,1'b1,12'h080,32'h0,32'h0,8'd5},               // R5
      '{1'b1,1'b1,12'h088,32'hFFFFFFFF,32'h0,8'd5},        // R5
      '{1'b0,1'b1,12'h088,32'h0,32'h0,8'd5},               // R5
      '{1'b0,1'b1,12'h084,32'h0,32'h0F0F0000,8'd5},        // R5
      '{1'b0,1'b1,12'h400,32'h0,32'h0,8'd5},               // R5
      '{1'b0,1'b1,12'h000,32'h0,32'h0,8'd5}                // R5
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_secure = 1'b0;
   logic [NUM_IRQ-33:0] irq_lines = '0;
   logic [31:0] bus_rdata;
   logic        bus_err;

   int tests = 0;
   int fails = 0;
   bit done = 0;
   logic [31:0] rv;
   logic        re;

   always #2.5 clk = ~clk;

   irqsec_bitmap #(.NUM_IRQ(NUM_IRQ)) u_irqsec_bitmap (
      .clk, .rst_n, .bus_valid, .bus_write, .bus_addr, .bus_wdata,
      .bus_secure, .irq_lines, .bus_rdata, .bus_err
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic acc(input logic w, input logic s, input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = w; bus_secure = s; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
      rv = bus_rdata;
      re = bus_err;
   endtask

   task automatic rd_chk(input string req, input logic s, input logic [11:0] a, input logic [31:0] exp);
      acc(1'b0, s, a, 32'h0);
      chk(req, rv, exp);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 rdata after reset", bus_rdata, 32'h0);
      chk("R1 err after reset", {31'b0, bus_err}, 32'h0);

      for (int i = 0; i < NV; i++) begin
         acc(VEC[i].wr, VEC[i].sec, VEC[i].addr, VEC[i].data);
         if (!VEC[i].wr) chk($sformatf("R%0d vector %0d", VEC[i].req, i), rv, VEC[i].exp);
      end

      // R11 error flag and timing
      acc(1'b0, 1'b1, 12'h700, 32'h0); chk("R11 err unmapped 0x700", {31'b0, re}, 32'h1);
      acc(1'b0, 1'b1, 12'h380, 32'h0); chk("R11 err unmapped 0x380", {31'b0, re}, 32'h1);
      acc(1'b0, 1'b1, 12'h086, 32'h0); chk("R11 err misaligned", {31'b0, re}, 32'h1);
      acc(1'b0, 1'b1, 12'h084, 32'h0);
      chk("R11 err clears", {31'b0, re}, 32'h0);
      chk("R11 data next cycle", rv, 32'h0F0F0000);

      // R6 / R7 line behaviour (irq32,33 edge; irq34 level)
      acc(1'b1, 1'b1, 12'h204, 32'hFFFFFFFF);
      @(negedge clk); irq_lines[0] = 1'b1;
      rd_chk("R6 edge latch", 1'b1, 12'h184, 32'h1);
      @(negedge clk); irq_lines[2] = 1'b1;
      rd_chk("R7 level OR", 1'b1, 12'h184, 32'h5);
      @(negedge clk); irq_lines[2] = 1'b0;
      rd_chk("R7 level drop", 1'b1, 12'h184, 32'h1);
      @(negedge clk); irq_lines[0] = 1'b0;
      rd_chk("R6 latched after drop", 1'b1, 12'h184, 32'h1);
      acc(1'b1, 1'b1, 12'h204, 32'h1);
      rd_chk("R6 cleared", 1'b1, 12'h184, 32'h0);
      @(negedge clk); irq_lines[1] = 1'b1;
      rd_chk("R6 edge irq33", 1'b1, 12'h184, 32'h2);
      acc(1'b1, 1'b1, 12'h204, 32'h2);
      repeat (2) @(negedge clk);
      rd_chk("R6 steady high ignored", 1'b1, 12'h184, 32'h0);
      @(negedge clk); irq_lines[1] = 1'b0;
      @(negedge clk);
      // R12 same-cycle clear and edge
      bus_valid = 1'b1; bus_write = 1'b1; bus_secure = 1'b1; bus_addr = 12'h204;
      bus_wdata = 32'h2; irq_lines[1] = 1'b1;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
      rd_chk("R12 edge beats clear", 1'b1, 12'h184, 32'h2);
      @(negedge clk); irq_lines = '0;

      // R10 security disable
      acc(1'b1, 1'b0, 12'h600, 32'h1);
      rd_chk("R10 ns set ignored", 1'b0, 12'h600, 32'h0);
      acc(1'b1, 1'b1, 12'h600, 32'h1);
      rd_chk("R10 flag set", 1'b1, 12'h600, 32'h1);
      acc(1'b1, 1'b1, 12'h600, 32'h0);
      rd_chk("R10 flag sticky", 1'b1, 12'h600, 32'h1);
      rd_chk("R10 group visible", 1'b0, 12'h004, 32'h0000FFFF);
      rd_chk("R9 nsac hidden when disabled", 1'b0, 12'h50C, 32'h0);
      acc(1'b1, 1'b0, 12'h084, 32'hF0000000);
      rd_chk("R10 ns full mask", 1'b0, 12'h084, 32'hFF0F0000);

      // R1 reset clears state
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk); rst_n = 1'b1;
      chk("R1 rdata after reset pulse", bus_rdata, 32'h0);
      rd_chk("R1 enable cleared", 1'b1, 12'h084, 32'h0);
      rd_chk("R1 flag cleared", 1'b1, 12'h600, 32'h0);
      rd_chk("R1 edge cleared", 1'b1, 12'h408, 32'h0);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule